// File: doc/BRIEF.md
# TSV Group Fault Classifier

This block serves one group of K through-silicon vias, M of which are spares. It receives K raw test-result bits from one of two places: the on-die prebond test circuits, or the TSV outputs sampled during a post-bond test. A conditioning stage can invert the odd-indexed and even-indexed bits on their own, so that a post-bond stimulus of all zeros, all ones or either checkerboard phase gives a word in which a 1 always marks a faulty via.

On a capture strobe, the block loads the conditioned word into a local result chain. On the same edge it registers a 2-bit check code: fault-free, repairable (no more faults than spares) or unrepairable (more faults than spares). An extraction controller reads the check code and raises the shift enable only for groups worth reading. The chain then shifts out LSB-first, one bit per clock. A serial input lets several groups be daisy-chained.

Top module: `tsv_group_classifier`

## Requirements
- R1: With `src_sel` = 0 the prebond bits are classified and captured. With `src_sel` = 1 the post-bond bits are used, and the other source has no effect.
- R2: `inv_odd` = 1 inverts bits at odd indices (1, 3, ...). `inv_even` = 1 inverts bits at even indices (0, 2, ...). Bit i of the conditioned word is the selected raw bit i XOR the matching control.
- R3: When a capture sees no conditioned bit set to 1, `check_code` becomes 2'b00 on that capture edge.
- R4: When a capture sees between 1 and M conditioned bits set to 1, `check_code` becomes 2'b01.
- R5: When a capture sees more than M conditioned bits set to 1, `check_code` becomes 2'b11. The code 2'b10 never appears.
- R6: `check_code` and the chain change only on a capture edge or, for the chain, a shift edge. Between captures, changes on the data and select inputs leave `check_code` unchanged.
- R7: On each edge with `shift_en` = 1 and `capture` = 0, the chain moves one place toward bit 0 and `scan_in` enters at bit K-1. `scan_out` is bit 0 of the chain, so a captured word leaves LSB-first over K clocks.
- R8: With `capture` = 0 and `shift_en` = 0, the chain holds and `scan_out` is stable.
- R9: When `capture` and `shift_en` are both 1 on the same edge, the capture wins and no shift takes place.
- R10: After reset, `check_code` is 2'b00 and every chain bit, including `scan_out`, is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prebond_bits | input | K | Results from the prebond test circuits |
| postbond_bits | input | K | Sampled TSV outputs in a post-bond test |
| src_sel | input | 1 | 0 selects prebond bits, 1 selects post-bond bits |
| inv_odd | input | 1 | Invert odd-indexed bits |
| inv_even | input | 1 | Invert even-indexed bits |
| capture | input | 1 | Load chain and check code |
| shift_en | input | 1 | Shift enable from the extraction controller |
| scan_in | input | 1 | Serial input from an upstream group |
| scan_out | output | 1 | Serial output, chain bit 0 |
| check_code | output | 2 | 00 fault-free, 01 repairable, 11 unrepairable |

## Verification
A capture or shift takes effect on the clock edge where it is sampled. Both `check_code` and `scan_out` are registered, so each result can be read in the same cycle, right after that edge. The bench drives inputs at the falling edge and updates its behavioural model at the rising edge. It compares both outputs at the next falling edge, exactly one rising edge after each stimulus. Idle cycles with changed data inputs confirm that nothing moves until the next strobe.

// File: rtl/tsv_cls_pkg.sv
package tsv_cls_pkg;
  typedef enum logic [1:0] {
    CC_CLEAN  = 2'b00,
    CC_REPAIR = 2'b01,
    CC_DEAD   = 2'b11
  } chk_code_e;

  // Three-way repair verdict from a fault count and the spare count.
  function automatic chk_code_e verdict(input int unsigned faults,
                                        input int unsigned spares);
    if (faults == 0)           return CC_CLEAN;
    else if (faults <= spares) return CC_REPAIR;
    else                       return CC_DEAD;
  endfunction
endpackage

// File: rtl/tsv_bit_conditioner.sv
module tsv_bit_conditioner #(
  parameter int K = 5
) (
  input  logic [K-1:0] pre_bits,
  input  logic [K-1:0] post_bits,
  input  logic         use_post,
  input  logic         flip_odd,
  input  logic         flip_even,
  output logic [K-1:0] cond_bits
);
  for (genvar i = 0; i < K; i++) begin : g_bit
    logic raw;
    assign raw = use_post ? post_bits[i] : pre_bits[i];
    if (i % 2 == 1) begin : g_odd
      assign cond_bits[i] = raw ^ flip_odd;
    end else begin : g_even
      assign cond_bits[i] = raw ^ flip_even;
    end
  end
endmodule

// File: rtl/tsv_fault_judge.sv
module tsv_fault_judge
  import tsv_cls_pkg::*;
#(
  parameter int K  = 5,
  parameter int M  = 1,
  localparam int CW = $clog2(K + 1)
) (
  input  logic [K-1:0]  cond_bits,
  output logic [CW-1:0] fault_cnt,
  output chk_code_e     code
);
  function automatic logic [CW-1:0] count_ones(input logic [K-1:0] v);
    logic [CW-1:0] acc;
    acc = '0;
    for (int i = 0; i < K; i++) acc = acc + CW'(v[i]);
    return acc;
  endfunction

  assign fault_cnt = count_ones(cond_bits);
  assign code      = verdict(int'(fault_cnt), M);
endmodule

// File: rtl/tsv_result_chain.sv
module tsv_result_chain #(
  parameter int K = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [K-1:0] load_bits,
  input  logic         shift,
  input  logic         sin,
  output logic [K-1:0] chain_q,
  output logic         sout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     chain_q <= '0;
    else if (load)  chain_q <= load_bits;
    else if (shift) begin
      if (K > 1) chain_q <= {sin, chain_q[K-1:1]};
      else       chain_q <= K'(sin);
    end
  end
  assign sout = chain_q[0];
endmodule

// File: rtl/tsv_group_classifier.sv
module tsv_group_classifier
  import tsv_cls_pkg::*;
#(
  parameter int K = 5,
  parameter int M = 1,
  localparam int CW = $clog2(K + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [K-1:0] prebond_bits,
  input  logic [K-1:0] postbond_bits,
  input  logic         src_sel,
  input  logic         inv_odd,
  input  logic         inv_even,
  input  logic         capture,
  input  logic         shift_en,
  input  logic         scan_in,
  output logic         scan_out,
  output logic [1:0]   check_code
);
  logic [K-1:0]  cond_bits;
  logic [CW-1:0] fault_cnt;
  chk_code_e     judge_code;
  chk_code_e     code_q;
  logic [K-1:0]  chain_q;

  tsv_bit_conditioner #(.K(K)) u_cond (
    .pre_bits (prebond_bits),
    .post_bits(postbond_bits),
    .use_post (src_sel),
    .flip_odd (inv_odd),
    .flip_even(inv_even),
    .cond_bits(cond_bits)
  );

  tsv_fault_judge #(.K(K), .M(M)) u_judge (
    .cond_bits(cond_bits),
    .fault_cnt(fault_cnt),
    .code     (judge_code)
  );

  tsv_result_chain #(.K(K)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (capture),
    .load_bits(cond_bits),
    .shift    (shift_en),
    .sin      (scan_in),
    .chain_q  (chain_q),
    .sout     (scan_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= CC_CLEAN;
    else if (capture) code_q <= judge_code;
  end

  assign check_code = code_q;
endmodule

// File: rtl/tsv_group_classifier_chk.sv
module tsv_group_classifier_chk #(
  parameter int K = 5,
  parameter int M = 1,
  localparam int CW = $clog2(K + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          capture,
  input logic          shift_en,
  input logic          scan_in,
  input logic          scan_out,
  input logic [1:0]    check_code,
  input logic [K-1:0]  chain_q,
  input logic [K-1:0]  cond_bits,
  input logic [CW-1:0] fault_cnt
);
  a_r5_no_code_10: assert property (@(posedge clk) disable iff (!rst_n)
    check_code != 2'b10);

  a_r3_clean_code: assert property (@(posedge clk) disable iff (!rst_n)
    capture && (cond_bits == '0) |=> check_code == 2'b00);

  a_r4_repair_code: assert property (@(posedge clk) disable iff (!rst_n)
    capture && (fault_cnt != 0) && (int'(fault_cnt) <= M) |=> check_code == 2'b01);

  a_r5_dead_code: assert property (@(posedge clk) disable iff (!rst_n)
    capture && (int'(fault_cnt) > M) |=> check_code == 2'b11);

  a_r6_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(check_code));

  a_r7_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en && !capture |=> chain_q[K-1] == $past(scan_in));

  a_r8_chain_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en && !capture |=> $stable(scan_out));

  a_r9_capture_wins: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> chain_q == $past(cond_bits));
endmodule

bind tsv_group_classifier tsv_group_classifier_chk #(.K(K), .M(M)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .capture   (capture),
  .shift_en  (shift_en),
  .scan_in   (scan_in),
  .scan_out  (scan_out),
  .check_code(check_code),
  .chain_q   (chain_q),
  .cond_bits (cond_bits),
  .fault_cnt (fault_cnt)
);

// File: tb/tsv_group_classifier_tb.sv
module tsv_group_classifier_tb;
  localparam int K = 5;
  localparam int M = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [K-1:0] prebond_bits = '0, postbond_bits = '0;
  logic src_sel = 0, inv_odd = 0, inv_even = 0;
  logic capture = 0, shift_en = 0, scan_in = 0;
  logic scan_out;
  logic [1:0] check_code;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit mchain[$];
  int mcode = 0;

  always #5 clk = ~clk;

  tsv_group_classifier #(.K(K), .M(M)) u_dut (
    .clk(clk), .rst_n(rst_n), .prebond_bits(prebond_bits),
    .postbond_bits(postbond_bits), .src_sel(src_sel), .inv_odd(inv_odd),
    .inv_even(inv_even), .capture(capture), .shift_en(shift_en),
    .scan_in(scan_in), .scan_out(scan_out), .check_code(check_code));

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Behavioural model step at a rising edge.
  task automatic model_edge();
    if (capture) begin
      int faults = 0;
      mchain.delete();
      for (int i = 0; i < K; i++) begin
        bit raw = src_sel ? postbond_bits[i] : prebond_bits[i];
        bit f = raw ^ ((i % 2 == 1) ? inv_odd : inv_even);
        mchain.push_back(f);
        faults += f;
      end
      mcode = (faults == 0) ? 0 : (faults <= M) ? 1 : 3;
    end else if (shift_en) begin
      void'(mchain.pop_front());
      mchain.push_back(scan_in);
    end
  endtask

  // Inputs are set at a falling edge; compare at the next falling edge.
  task automatic cyc(string req, bit cap, bit sh, bit si);
    capture = cap; shift_en = sh; scan_in = si;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check({req, " code"}, int'(check_code), mcode);
    check({req, " sout"}, int'(scan_out), int'(mchain[0]));
  endtask

  task automatic setup(bit s, bit io, bit ie, logic [K-1:0] pre, logic [K-1:0] post);
    src_sel = s; inv_odd = io; inv_even = ie;
    prebond_bits = pre; postbond_bits = post;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    for (int i = 0; i < K; i++) mchain.push_back(0);
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 code", int'(check_code), 0);
    check("R10 sout", int'(scan_out), 0);
    rst_n = 1;
    @(negedge clk);

    // R3 prebond clean
    setup(0, 0, 0, 5'b00000, 5'b11111);
    cyc("R3", 1, 0, 0);
    check("R3 direct", int'(check_code), 0);
    // R4 prebond single fault at bit 2, then R7 LSB-first shift out
    setup(0, 0, 0, 5'b00100, 5'b00000);
    cyc("R4", 1, 0, 0);
    check("R4 direct", int'(check_code), 1);
    for (int i = 0; i < K; i++) cyc("R7 unload", 0, 1, i[0]);
    // R7 bits entered via scan_in now stream out
    for (int i = 0; i < K; i++) begin
      check("R7 chained", int'(scan_out), i % 2);
      cyc("R7 chain", 0, 1, 0);
    end
    // R5 two faults
    setup(0, 0, 0, 5'b10001, 5'b00000);
    cyc("R5", 1, 0, 0);
    check("R5 direct", int'(check_code), 3);
    // R1 post-bond all-0 pattern, prebond side all faulty
    setup(1, 0, 0, 5'b11111, 5'b00000);
    cyc("R1", 1, 0, 0);
    check("R1 direct", int'(check_code), 0);
    // R1 prebond selected, post side noisy
    setup(0, 0, 0, 5'b00000, 5'b11111);
    cyc("R1 pre", 1, 0, 0);
    // R2 all-1 pattern
    setup(1, 1, 1, 5'b00000, 5'b11111);
    cyc("R2 all1", 1, 0, 0);
    check("R2 all1 direct", int'(check_code), 0);
    setup(1, 1, 1, 5'b00000, 5'b11011);
    cyc("R2 all1 fault", 1, 0, 0);
    // R2 checkerboard both phases
    setup(1, 1, 0, 5'b00000, 5'b01010);
    cyc("R2 cb a", 1, 0, 0);
    check("R2 cb a direct", int'(check_code), 0);
    setup(1, 0, 1, 5'b00000, 5'b10101);
    cyc("R2 cb b", 1, 0, 0);
    // R2 odd-only inversion of zeros: bits 1,3 faulty -> 11
    setup(1, 1, 0, 5'b00000, 5'b00000);
    cyc("R2 odd", 1, 0, 0);
    check("R2 odd direct", int'(check_code), 3);
    // R6 / R8 idle with changing inputs
    setup(0, 0, 0, 5'b00010, 5'b00000);
    cyc("R6 load", 1, 0, 0);
    setup(0, 0, 0, 5'b11111, 5'b11111);
    for (int i = 0; i < 4; i++) cyc("R6 R8 idle", 0, 0, 1);
    check("R6 direct", int'(check_code), 1);
    // R9 capture over shift
    setup(0, 0, 0, 5'b00001, 5'b00000);
    cyc("R9", 1, 1, 0);
    check("R9 direct", int'(scan_out), 1);
    // mixed random traffic
    for (int i = 0; i < 300; i++) begin
      setup($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
            K'($urandom), K'($urandom));
      cyc("R6 random", ($urandom_range(0, 3) == 0), $urandom_range(0, 1),
          $urandom_range(0, 1));
    end
    finish_run();
  end
endmodule